// File: doc/BRIEF.md
# I2C Register-Mapped GPIO Expander

This block is an I2C target that gives a host eight general-purpose pins through four byte-wide registers. The host writes a one-byte register pointer and then a value to update a register. To read, it writes the pointer alone, issues a repeated START, and clocks the selected byte out. The registers are:

- a live input view of the pins, with optional per-bit inversion;
- an output latch;
- a polarity mask;
- a direction mask.

The direction mask sets, pin by pin, whether the pad is left floating as an input or driven from the output latch. The input view is sampled through a synchronizer.

The block also produces an active-low, open-drain interrupt request. The request asserts when any pin configured as an input no longer matches the value captured at the last read of the input register. A read of that register, or the pin returning to the captured level, releases the line. Both SDA and the interrupt are modelled as pull-down enables (`1` means drive the wire low). SCL is oversampled by the system clock, so the block never stretches the clock.

Top module: `gpx_expander`

## Requirements
- R1: After reset the output latch is 0xFF, the polarity mask 0x00 and the direction mask 0xFF. So `pin_oe` is 0x00, `pin_o` is 0xFF, and both `sda_oe` and `irq_oe` are 0.
- R2: The address byte is the 7-bit address followed by the direction bit (1 = read). The block ACKs an address byte equal to `DEV_ADDR` (default 0x20) by pulling SDA low in the ninth clock. Any other address gets no ACK, and the rest of that transaction is ignored until the next START.
- R3: In a write transaction every byte is ACKed. The first byte after the address sets the pointer. Each later byte is stored in the selected register: 1 is the output latch, 2 the polarity mask, 3 the direction mask.
- R4: A read transaction returns the register selected by the pointer, MSB first. While the host ACKs, the same register is sent again. A host NACK ends the transfer.
- R5: Only pointer bits [1:0] are used, so pointers 5, 6 and 7 select registers 1, 2 and 3.
- R6: Direction bit 1 makes the pin an input (`pin_oe` bit 0). Direction bit 0 drives the pin (`pin_oe` bit 1). `pin_o` always equals the output latch.
- R7: A polarity bit of 1 inverts only that bit of the register-0 read value. `pin_o`, `pin_oe` and the interrupt are unaffected.
- R8: A data byte written while the pointer selects register 0 changes no register.
- R9: `irq_oe` goes to 1 within SYNC_STAGES+1 clocks after an input-configured pin settles at a level different from its reference bit. The reference is all ones after reset.
- R10: When a register-0 byte is loaded for a read, the reference takes the current pin levels and `irq_oe` drops. `irq_oe` also drops when the pins return to the reference.
- R11: Pins whose direction bit is 0 never raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the I2C bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock level seen on the wire |
| sda_i | input | 1 | I2C data level seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| pin_i | input | 8 | Pad levels |
| pin_o | output | 8 | Pad drive values |
| pin_oe | output | 8 | Per-pin drive enable, 1 = driven |
| irq_oe | output | 1 | 1 pulls the interrupt wire low |

## Verification
Most of the state in this block shows up at the ports quickly. A corrupted output latch or direction mask is visible on `pin_o` or `pin_oe` one clock after the data byte's eighth SCL rise. A wrong pointer only shows up on the next read-back, so every write is followed by a read through a possibly aliased pointer. A stale interrupt reference stays hidden until an input pin moves. That is why the bench toggles input pins both away from and back to the captured value, and checks `irq_oe` a few clocks later.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2;

  localparam logic [PTR_W-1:0] REG_IN  = 2'd0;
  localparam logic [PTR_W-1:0] REG_OUT = 2'd1;
  localparam logic [PTR_W-1:0] REG_POL = 2'd2;
  localparam logic [PTR_W-1:0] REG_CFG = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target
  import gpx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h20,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic              wr_first,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              rd_load,
  input  logic [BYTE_W-1:0] rd_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [1:0] bus_s;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (bus_s)
  );

  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  tgt_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] nxt_byte;
  logic              rw_q, ack_on, first_q, more_q;

  assign nxt_byte = {shreg[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      rw_q     <= 1'b0;
      ack_on   <= 1'b0;
      first_q  <= 1'b0;
      more_q   <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_first <= 1'b0;
      wr_byte  <= '0;
      rd_load  <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_load  <= 1'b0;
      if (start_det) begin
        st      <= ST_ADDR;
        cnt     <= '0;
        ack_on  <= 1'b0;
        sda_oe  <= 1'b0;
        first_q <= 1'b1;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        ack_on <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (scl_rise) begin
            shreg <= nxt_byte;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              if (nxt_byte[BYTE_W-1:1] == DEV_ADDR) begin
                st   <= ST_ADDR_ACK;
                rw_q <= nxt_byte[0];
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_WR: if (scl_rise) begin
            shreg <= nxt_byte;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              wr_valid <= 1'b1;
              wr_first <= first_q;
              wr_byte  <= nxt_byte;
              first_q  <= 1'b0;
              st       <= ST_WR_ACK;
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              cnt    <= '0;
              if (st == ST_ADDR_ACK && rw_q) begin
                st      <= ST_RD;
                shreg   <= rd_data;
                rd_load <= 1'b1;
                sda_oe  <= ~rd_data[BYTE_W-1];
              end else begin
                st     <= ST_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RD: if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              st     <= ST_RD_ACK;
            end else begin
              cnt    <= cnt + 1'b1;
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~shreg[BYTE_W-2];
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) more_q <= ~sda_s;
            if (scl_fall) begin
              if (more_q) begin
                st      <= ST_RD;
                cnt     <= '0;
                shreg   <= rd_data;
                rd_load <= 1'b1;
                sda_oe  <= ~rd_data[BYTE_W-1];
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> !sda_oe);

  // R3
  ack_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              wr_first,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_load,
  input  logic [BYTE_W-1:0] pins_s,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] out_q,
  output logic [BYTE_W-1:0] cfg_q,
  output logic              rd_in_pulse
);
  logic [PTR_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= REG_IN;
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else if (wr_valid) begin
      if (wr_first) begin
        ptr_q <= wr_byte[PTR_W-1:0];
      end else begin
        case (ptr_q)
          REG_OUT: out_q <= wr_byte;
          REG_POL: pol_q <= wr_byte;
          REG_CFG: cfg_q <= wr_byte;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (ptr_q)
      REG_IN:  rd_data = pins_s ^ pol_q;
      REG_OUT: rd_data = out_q;
      REG_POL: rd_data = pol_q;
      default: rd_data = cfg_q;
    endcase
  end

  assign rd_in_pulse = rd_load && (ptr_q == REG_IN);

  // R8
  in_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_first && ptr_q == REG_IN) |=>
      ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));

  // R3
  out_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_first && ptr_q == REG_OUT) |=> out_q == $past(wr_byte));
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] pins_s,
  input  logic [BYTE_W-1:0] in_mask,
  input  logic              capture,
  output logic              irq_oe
);
  logic [BYTE_W-1:0] snap_q;
  logic [BYTE_W-1:0] diff;

  assign diff = (pins_s ^ snap_q) & in_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '1;
      irq_oe <= 1'b0;
    end else begin
      if (capture) snap_q <= pins_s;
      irq_oe <= |diff;
    end
  end

  // R11
  output_pins_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_mask == '0) |=> !irq_oe);
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h20,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] pin_o,
  output logic [BYTE_W-1:0] pin_oe,
  output logic              irq_oe
);
  logic              wr_valid, wr_first, rd_load, rd_in_pulse;
  logic [BYTE_W-1:0] wr_byte, rd_data, pins_s, out_q, cfg_q;

  gpx_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_pin_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_i),
    .q   (pins_s)
  );

  gpx_i2c_target #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_tgt (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_first (wr_first),
    .wr_byte  (wr_byte),
    .rd_load  (rd_load),
    .rd_data  (rd_data)
  );

  gpx_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_valid    (wr_valid),
    .wr_first    (wr_first),
    .wr_byte     (wr_byte),
    .rd_load     (rd_load),
    .pins_s      (pins_s),
    .rd_data     (rd_data),
    .out_q       (out_q),
    .cfg_q       (cfg_q),
    .rd_in_pulse (rd_in_pulse)
  );

  gpx_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .pins_s  (pins_s),
    .in_mask (cfg_q),
    .capture (rd_in_pulse),
    .irq_oe  (irq_oe)
  );

  assign pin_o  = out_q;
  assign pin_oe = ~cfg_q;
endmodule

// File: tb/gpx_expander_test.sv
module gpx_expander_test;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_low = 1'b0;
  logic sda_low = 1'b0;
  logic [7:0] ext = 8'hFF;
  logic sda_oe, irq_oe;
  logic [7:0] pin_o, pin_oe, pin_i;
  wire scl_w = ~scl_low;
  wire sda_w = ~(sda_low | sda_oe);

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign pin_i = (pin_oe & pin_o) | (~pin_oe & ext);

  gpx_expander #(.DEV_ADDR(ADDR)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_w), .sda_i(sda_w), .sda_oe(sda_oe),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq_oe(irq_oe)
  );

  // wptr, wdata, rptr, expected read
  localparam logic [31:0] VEC [7] = '{
    32'h03_F0_03_F0, 32'h01_A5_01_A5, 32'h02_3C_02_3C, 32'h05_5A_01_5A,
    32'h07_0F_03_0F, 32'h00_12_03_0F, 32'h06_00_02_00 };
  string vtag [7] = '{"R3", "R3", "R3", "R5", "R5", "R8", "R5"};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_low = 0; qwait(); scl_low = 0; qwait();
    sda_low = 1; qwait(); scl_low = 1; qwait();
  endtask

  task automatic bus_stop();
    sda_low = 1; qwait(); scl_low = 0; qwait(); sda_low = 0; qwait();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_low = ~b[i]; qwait(); scl_low = 0; qwait(); qwait(); scl_low = 1; qwait();
    end
    sda_low = 0; qwait(); scl_low = 0; qwait();
    acked = ~sda_w;
    qwait(); scl_low = 1; qwait();
  endtask

  task automatic rx_byte(input logic host_ack, output logic [7:0] b);
    sda_low = 0;
    for (int i = 7; i >= 0; i--) begin
      qwait(); scl_low = 0; qwait(); b[i] = sda_w; qwait(); scl_low = 1; qwait();
    end
    sda_low = host_ack; qwait(); scl_low = 0; qwait(); qwait(); scl_low = 1; qwait();
    sda_low = 0;
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                           output logic [2:0] acks);
    bus_start();
    tx_byte({a, 1'b0}, acks[2]);
    tx_byte(p, acks[1]);
    tx_byte(d, acks[0]);
    bus_stop();
    repeat (4) @(negedge clk);
  endtask

  task automatic read_reg(input logic [7:0] p, input int n, output logic [7:0] d0,
                          output logic [7:0] d1, output logic [2:0] acks);
    bus_start();
    tx_byte({ADDR, 1'b0}, acks[2]);
    tx_byte(p, acks[1]);
    bus_start();
    tx_byte({ADDR, 1'b1}, acks[0]);
    d1 = 8'h00;
    rx_byte(n > 1, d0);
    if (n > 1) rx_byte(1'b0, d1);
    bus_stop();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2:0] ak;
    logic [7:0] r0, r1;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);

    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_o", pin_o, 8'hFF);
    chk("R1 irq_oe", {7'd0, irq_oe}, 8'h00);
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    read_reg(8'h01, 1, r0, r1, ak); chk("R1 out reg", r0, 8'hFF);
    chk("R4 read acks", {5'd0, ak}, 8'h07);
    read_reg(8'h02, 1, r0, r1, ak); chk("R1 pol reg", r0, 8'h00);
    read_reg(8'h03, 1, r0, r1, ak); chk("R1 cfg reg", r0, 8'hFF);

    for (int k = 0; k < 7; k++) begin
      write_reg(ADDR, VEC[k][31:24], VEC[k][23:16], ak);
      chk("R3 write acks", {5'd0, ak}, 8'h07);
      read_reg(VEC[k][15:8], 1, r0, r1, ak);
      chk(vtag[k], r0, VEC[k][7:0]);
    end

    chk("R6 pin_oe", pin_oe, 8'hF0);
    chk("R6 pin_o", pin_o, 8'h5A);
    chk("R8 pin_o after reg0 write", pin_o, 8'h5A);
    chk("R9 idle irq", {7'd0, irq_oe}, 8'h00);

    ext = 8'hFA;
    repeat (6) @(negedge clk);
    chk("R9 irq on change", {7'd0, irq_oe}, 8'h01);
    read_reg(8'h00, 1, r0, r1, ak);
    chk("R4 input reg", r0, 8'h5A);
    chk("R10 irq cleared by read", {7'd0, irq_oe}, 8'h00);

    ext = 8'hF8;
    repeat (6) @(negedge clk);
    chk("R9 irq second change", {7'd0, irq_oe}, 8'h01);
    ext = 8'hFA;
    repeat (6) @(negedge clk);
    chk("R10 irq cleared by return", {7'd0, irq_oe}, 8'h00);

    write_reg(ADDR, 8'h02, 8'h0F, ak);
    read_reg(8'h00, 1, r0, r1, ak);
    chk("R7 inverted input", r0, 8'h55);
    chk("R7 pin_o unaffected", pin_o, 8'h5A);
    chk("R7 pin_oe unaffected", pin_oe, 8'hF0);
    chk("R7 irq unaffected", {7'd0, irq_oe}, 8'h00);

    write_reg(ADDR, 8'h01, 8'hA5, ak);
    repeat (6) @(negedge clk);
    chk("R6 pin_o follows", pin_o, 8'hA5);
    chk("R11 output change no irq", {7'd0, irq_oe}, 8'h00);

    write_reg(7'h21, 8'h01, 8'h00, ak);
    chk("R2 foreign address nack", {7'd0, ak[2]}, 8'h00);
    chk("R2 foreign write ignored", pin_o, 8'hA5);

    read_reg(8'h07, 2, r0, r1, ak);
    chk("R5 alias ptr 7 first", r0, 8'h0F);
    chk("R4 repeat byte", r1, 8'h0F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule